// File: doc/BRIEF.md
# Range-Offset Address Routing Descriptor

This block is one address-decode descriptor of an on-chip interconnect. A single 64-bit configuration word, loaded through a write port and always visible on a separate read-back port, describes a window of 4 KB pages. The word holds an inclusive lower and upper page bound, a signed page offset, a compare value for the request's special-cycle flag and a 3-bit destination port. Requests carry a 32-bit physical address and a special-cycle flag. A low flag marks an ordinary memory or I/O cycle. A high flag marks a special cycle such as shutdown or halt.

Requests enter on a valid/ready handshake. A request hits when its page number (address bits 31:12) lies within the window and its special-cycle flag equals the compare bit. On a hit the block reports the programmed destination port and a relocated address: the offset is added to the page number modulo 2^20, and the 12 in-page bits pass through unchanged. On a miss it reports port 0 and the untouched address. The verdict sits in a one-entry output register that holds its value until the consumer takes it. A small two-state machine controls this register. OUT_EMPTY moves to OUT_FULL when a request is accepted. OUT_FULL stays in OUT_FULL when a new request is accepted or the consumer stalls. OUT_FULL returns to OUT_EMPTY when the consumer drains the entry and no request arrives.

Top module: `rngofs_route`

## Requirements
- R1: After reset, the read-back word is 64'h00000000_000FFFFF, rsp_valid is 0 and req_ready is 1.
- R2: A cycle with cfg_wr_en high loads cfg_wr_data, and the new word appears on cfg_rd_data after that clock edge. The fields are: bits 63:61 destination port, bit 60 special-cycle compare, bits 59:40 page offset, bits 39:20 upper page bound, bits 19:0 lower page bound.
- R3: rsp_hit is 1 exactly when the request's address bits 31:12, taken as unsigned, are greater than or equal to the lower bound and less than or equal to the upper bound, and req_special equals bit 60.
- R4: On a hit, rsp_port equals configuration bits 63:61. The eight values 000 to 111 each select one port.
- R5: On a hit, rsp_addr[31:12] = (req_addr[31:12] + offset) mod 2^20, with the offset in two's complement. rsp_addr[11:0] equals req_addr[11:0].
- R6: On a miss, rsp_hit is 0, rsp_port is 0 and rsp_addr equals req_addr.
- R7: A request is accepted in a cycle where req_valid and req_ready are both high. Its verdict appears with rsp_valid high after the next clock edge.
- R8: req_ready is low only while rsp_valid is high and rsp_ready is low. While stalled, rsp_valid, rsp_hit, rsp_port and rsp_addr hold their values.
- R9: A request accepted in the same cycle as a configuration write is decoded with the previous configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Load the configuration word |
| cfg_wr_data | input | 64 | Configuration word to load |
| cfg_rd_data | output | 64 | Current configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Physical address of the request |
| req_special | input | 1 | Special-cycle flag of the request |
| rsp_valid | output | 1 | Verdict register holds a result |
| rsp_ready | input | 1 | Consumer takes the verdict this cycle |
| rsp_hit | output | 1 | Request fell inside the window |
| rsp_port | output | 3 | Destination port, 0 on a miss |
| rsp_addr | output | 32 | Relocated address, or the original address on a miss |

## Verification
Every verdict is due one clock edge after the cycle in which its request is accepted, and it stays unchanged for each further cycle that rsp_ready is low. The read-back word is due one edge after a write. req_ready is combinational from rsp_valid and rsp_ready, so it is due within the same cycle. The bench drives inputs at the falling edge and keeps a model of the one-entry register. At the next falling edge it compares every output with that model. A verdict is predicted from the configuration that was in place before the accepting edge, which covers the case of a write in the same cycle.

// File: rtl/rngofs_pkg.sv
package rngofs_pkg;
    parameter int unsigned ADDR_W   = 32;
    parameter int unsigned PAGE_SH  = 12;
    parameter int unsigned PORT_W   = 3;
    localparam int unsigned PAGE_W  = ADDR_W - PAGE_SH;
    localparam int unsigned CFG_W   = PORT_W + 1 + 3 * PAGE_W;

    typedef struct packed {
        logic [PORT_W-1:0] dest;
        logic              want_special;
        logic [PAGE_W-1:0] shift;
        logic [PAGE_W-1:0] top;
        logic [PAGE_W-1:0] base;
    } desc_t;

    typedef struct packed {
        logic              hit;
        logic [PORT_W-1:0] port;
        logic [ADDR_W-1:0] addr;
    } verdict_t;

    typedef enum logic [0:0] {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

    localparam logic [CFG_W-1:0] DESC_RESET = {{(CFG_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};
endpackage

// File: rtl/rngofs_cfg.sv
module rngofs_cfg
    import rngofs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output desc_t            desc
);
    desc_t word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= desc_t'(DESC_RESET);
        end else if (wr_en) begin
            word_q <= desc_t'(wr_data);
        end
    end

    assign desc = word_q;
endmodule

// File: rtl/rngofs_match.sv
module rngofs_match
    import rngofs_pkg::*;
(
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] addr,
    input  logic              special,
    output verdict_t          verdict
);
    logic [PAGE_W-1:0]  page;
    logic [PAGE_W-1:0]  moved;
    logic [PAGE_SH-1:0] inpage;
    logic               above_base;
    logic               below_top;
    logic               flag_ok;
    logic               hit;

    always_comb begin
        page       = addr[ADDR_W-1:PAGE_SH];
        inpage     = addr[PAGE_SH-1:0];
        above_base = (page >= desc.base);
        below_top  = (page <= desc.top);
        flag_ok    = (special == desc.want_special);
        hit        = above_base && below_top && flag_ok;
        moved      = page + desc.shift;
    end

    always_comb begin
        verdict.hit = hit;
        if (hit) begin
            verdict.port = desc.dest;
            verdict.addr = {moved, inpage};
        end else begin
            verdict.port = '0;
            verdict.addr = addr;
        end
    end
endmodule

// File: rtl/rngofs_out.sv
module rngofs_out
    import rngofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    output logic     in_ready,
    input  verdict_t in_verdict,
    output logic     out_valid,
    input  logic     out_ready,
    output verdict_t out_verdict
);
    out_state_e state_q;
    out_state_e state_d;
    verdict_t   hold_q;
    logic       take;

    always_comb begin
        in_ready = (state_q == OUT_EMPTY) || out_ready;
        take     = in_valid && in_ready;
        state_d  = state_q;
        unique case (state_q)
            OUT_EMPTY: if (take) state_d = OUT_FULL;
            OUT_FULL:  if (out_ready && !take) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= in_verdict;
        end
    end

    assign out_valid   = (state_q == OUT_FULL);
    assign out_verdict = hold_q;
endmodule

// File: rtl/rngofs_route.sv
module rngofs_route
    import rngofs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_special,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port,
    output logic [ADDR_W-1:0] rsp_addr
);
    desc_t    desc;
    verdict_t fresh;
    verdict_t held;

    rngofs_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .desc    (desc)
    );

    rngofs_match u_match (
        .desc    (desc),
        .addr    (req_addr),
        .special (req_special),
        .verdict (fresh)
    );

    rngofs_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (req_valid),
        .in_ready    (req_ready),
        .in_verdict  (fresh),
        .out_valid   (rsp_valid),
        .out_ready   (rsp_ready),
        .out_verdict (held)
    );

    assign cfg_rd_data = desc;
    assign rsp_hit     = held.hit;
    assign rsp_port    = held.port;
    assign rsp_addr    = held.addr;
endmodule

// File: rtl/rngofs_chk.sv
module rngofs_chk
    import rngofs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_W-1:0]  cfg_wr_data,
    input logic [CFG_W-1:0]  cfg_rd_data,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_hit,
    input logic [PORT_W-1:0] rsp_port,
    input logic [ADDR_W-1:0] rsp_addr
);
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data)); // R2

    AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_port == '0); // R6

    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R7

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit)
            && $stable(rsp_port) && $stable(rsp_addr)); // R8
endmodule

bind rngofs_route rngofs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_hit     (rsp_hit),
    .rsp_port    (rsp_port),
    .rsp_addr    (rsp_addr)
);

// File: tb/rngofs_route_tb.sv
module rngofs_route_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic [63:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_special = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_hit;
    logic [2:0]  rsp_port;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_cfg = 64'h00000000_000FFFFF;
    logic        m_valid = 1'b0;
    logic        m_hit = 1'b0;
    logic [2:0]  m_port = '0;
    logic [31:0] m_addr = '0;

    always #10 clk = ~clk;

    rngofs_route u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_special(req_special), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_hit(rsp_hit), .rsp_port(rsp_port), .rsp_addr(rsp_addr)
    );

    function automatic logic [35:0] predict(logic [63:0] c, logic [31:0] a, logic s);
        logic [19:0] pg;
        logic        h;
        pg = a[31:12];
        h  = (pg >= c[19:0]) && (pg <= c[39:20]) && (s == c[60]);
        if (h) return {1'b1, c[63:61], pg + c[59:40], a[11:0]};
        return {1'b0, 3'd0, a};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: check outputs, drive one cycle, advance model.
    task automatic step(bit wr, logic [63:0] wd, bit v, logic [31:0] a, bit s, bit rdy);
        logic [35:0] p;
        bit acc;
        check("R2 readback", cfg_rd_data, m_cfg);
        check("R7 rsp_valid", rsp_valid, m_valid);
        if (m_valid) begin
            check("R3 rsp_hit", rsp_hit, m_hit);
            check(m_hit ? "R4 rsp_port" : "R6 rsp_port", rsp_port, m_port);
            check(m_hit ? "R5 rsp_addr" : "R6 rsp_addr", rsp_addr, m_addr);
        end
        cfg_wr_en = wr; cfg_wr_data = wd; req_valid = v; req_addr = a;
        req_special = s; rsp_ready = rdy;
        #1;
        check("R8 req_ready", req_ready, !m_valid || rdy);
        acc = v && (!m_valid || rdy);
        if (acc) begin
            p = predict(m_cfg, a, s);
            m_valid = 1'b1; m_hit = p[35]; m_port = p[34:32]; m_addr = p[31:0];
        end else if (rdy) begin
            m_valid = 1'b0;
        end
        if (wr) m_cfg = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] mk(logic [2:0] pt, bit sp, logic [19:0] off,
                                       logic [19:0] hi, logic [19:0] lo);
        return {pt, sp, off, hi, lo};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] cw;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 cfg reset", cfg_rd_data, 64'h00000000_000FFFFF);
        check("R1 rsp_valid reset", rsp_valid, 1'b0);
        check("R1 req_ready reset", req_ready, 1'b1);
        // R1/R3: reset window is empty, page 0 misses
        step(0, 0, 1, 32'h0000_0123, 0, 1);
        // R3/R4/R5 directed window: pages 0x00100..0x001FF, offset -16, port 5
        cw = mk(3'd5, 1'b0, 20'hFFFF0, 20'h001FF, 20'h00100);
        step(1, cw, 0, 0, 0, 1);
        step(0, 0, 1, 32'h0010_0ABC, 0, 1);  // lower bound hits
        step(0, 0, 1, 32'h001F_F001, 0, 1);  // upper bound hits
        step(0, 0, 1, 32'h000F_FFFF, 0, 1);  // one below misses
        step(0, 0, 1, 32'h0020_0000, 0, 1);  // one above misses
        step(0, 0, 1, 32'h0015_0000, 1, 1);  // special mismatch misses
        // special-cycle window, wrap of the page sum (R5)
        cw = mk(3'd7, 1'b1, 20'h00002, 20'hFFFFF, 20'hFFFF0);
        step(1, cw, 0, 0, 0, 1);
        step(0, 0, 1, 32'hFFFF_F123, 1, 1);  // 0xFFFFF+2 -> 0x00001
        step(0, 0, 1, 32'hFFFF_F123, 0, 1);
        // R8 stall: hold verdict two cycles, new request blocked
        step(0, 0, 1, 32'hFFFF_0456, 1, 0);
        step(0, 0, 1, 32'h1234_5678, 0, 0);
        step(0, 0, 1, 32'h1234_5678, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        // R9: write in the same cycle as an accepted request
        cw = mk(3'd2, 1'b0, 20'h00010, 20'h00FFF, 20'h00000);
        step(1, cw, 1, 32'hFFFF_A000, 1, 1);
        checks++;
        if (!(rsp_valid && rsp_hit && rsp_port == 3'd7 && rsp_addr == 32'hFFFF_C000)) begin
            errors++;
            $display("FAIL R9 actual=%b/%b/%0d/%h expected=1/1/7/ffffc000",
                     rsp_valid, rsp_hit, rsp_port, rsp_addr);
        end
        step(0, 0, 1, 32'h0000_5010, 0, 1);
        // every port code on a hit (R4)
        for (int k = 0; k < 8; k++) begin
            step(1, mk(3'(k), 1'b0, 20'h0, 20'h00010, 20'h00010), 0, 0, 0, 1);
            step(0, 0, 1, 32'h0001_0000 | 32'(k), 0, 1);
        end
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] lo, span, pg;
            bit wr, v, s, rdy;
            lo = 20'($urandom);
            span = 20'($urandom % 64);
            wr = ($urandom % 16) == 0;
            cw = mk(3'($urandom), 1'($urandom % 4 == 0), 20'($urandom),
                    lo + span, lo);
            pg = m_cfg[19:0] + 20'($urandom % 72) - 20'd4;
            v = ($urandom % 10) < 7;
            s = (($urandom % 5) == 0) ? !m_cfg[60] : m_cfg[60];
            rdy = ($urandom % 4) != 0;
            step(wr, cw, v, {pg, 12'($urandom)}, s, rdy);
        end
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule